// File: doc/BRIEF.md
# Time-Multiplexed Overlay Processing Element

This block is one compute tile of a statically scheduled reconfigurable array whose resources are shared over time. Two 32-bit operand streams come in from the neighbouring network. Each stream enters its own 16-deep delay line, which advances on every clock. A value that arrived earlier therefore sits at a deeper tap. A compiler has fixed in advance the cycle in which each value arrives, so the tile picks operands by their tap position. It does not use register addresses or a handshake.

A context counter steps through a repeating window of II slots, where II is set at run time from 1 to 16. The counter indexes a small configuration memory. The word for the current slot selects one tap of each delay line as the two ALU inputs, the operation, and whether the result is emitted. Different slots can run different operations on the same tile. The result is registered and appears one cycle after selection.

The configuration memory and II are loaded through a write port while the global `run` input is low. The data ports carry no valid/ready signals and the tile never applies back-pressure. The downstream side must take `res_data` in the cycle that `res_en` is high, exactly as the schedule assumes.

Top module: `tmpe_tile`

## Requirements
- R1: After reset, `res_en` is 0, `res_data` is 0, `ctx_slot` is 0, II is 1, every delay-line tap is 0, and every context word is 0.
- R2: An operand present on `in_a`/`in_b` at clock edge n is selected by tap value k at clock edge n+k+1, for k from 0 to 15. Both delay lines advance on every clock, whether or not `run` is high.
- R3: The 12-bit context word has this layout:
  - bits 2:0 are the opcode: 0 = A+B, 1 = A−B (modulo 2^32), 2 = A AND B, 3 = A OR B, 4 = A XOR B, 5 = A, 6 = B, 7 = zero.
  - bits 6:3 select the tap for A (from `in_a`).
  - bits 10:7 select the tap for B (from `in_b`).
  - bit 11 is the output enable.
- R4: At each clock edge where `run` is high, `res_en` becomes the output-enable bit of the context slot current before that edge. When it is 1, `res_data` becomes the ALU result for that slot's taps and opcode. When `run` is low at the edge, `res_en` becomes 0.
- R5: When `res_en` is 0, `res_data` keeps its previous value.
- R6: While `run` is high, `ctx_slot` counts 0, 1, …, II−1 and then wraps to 0.
- R7: At every clock edge where `run` is low, `ctx_slot` becomes 0. The first edge with `run` high therefore uses slot 0.
- R8: A write with `cfg_we` high and `run` low takes effect at that clock edge. If `cfg_addr[4]` is 0, the write stores `cfg_data` into context word `cfg_addr[3:0]`. If `cfg_addr[4]` is 1, the write sets II to `cfg_data[3:0]`+1.
- R9: A write attempted while `run` is high changes neither a context word nor II.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Global run; configuration is allowed only while low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Bit 4 selects the II register; bits 3:0 give the context index |
| cfg_data | input | 12 | Context word, or II−1 in bits 3:0 |
| in_a | input | 32 | Operand stream A |
| in_b | input | 32 | Operand stream B |
| res_data | output | 32 | Registered ALU result |
| res_en | output | 1 | Result emitted this cycle |
| ctx_slot | output | 4 | Current context slot |

## Verification
Two functions can fall in the same cycle:
- The wrap of the context counter back to slot 0 coincides with a slot that emits a result.
- A configuration write coincides with `run` being high.

The bench sets up windows of II 1, 4 and 16 so that enabled slots sit on the last slot before the wrap. A scoreboard predicts each edge from its own delay-line and schedule model, so a wrong wrap shows up as a mismatched result or slot number. Writes issued during a run are left out of the model's configuration. Any later result that reflects the write is reported as a failure.

// File: rtl/tmpe_pkg.sv
package tmpe_pkg;
  localparam int DW     = 32;
  localparam int DEPTH  = 16;
  localparam int NCTX   = 16;
  localparam int TAP_W  = $clog2(DEPTH);
  localparam int CTX_W  = $clog2(NCTX);
  localparam int OP_W   = 3;
  localparam int WORD_W = 1 + 2 * TAP_W + OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_PA   = 3'd5,
    OP_PB   = 3'd6,
    OP_ZERO = 3'd7
  } op_e;

  typedef struct packed {
    logic             oe;
    logic [TAP_W-1:0] tap_b;
    logic [TAP_W-1:0] tap_a;
    op_e              op;
  } ctx_word_t;
endpackage

// File: rtl/tmpe_delay_line.sv
module tmpe_delay_line
  import tmpe_pkg::*;
#(
  parameter int W = DW,
  parameter int N = DEPTH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        din,
  output logic [N-1:0][W-1:0] taps
);
  logic [N-1:0][W-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= din;
  end

  for (genvar g = 1; g < N; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[g] <= '0;
      else        stage[g] <= stage[g-1];
    end
  end

  assign taps = stage;

  // R2
  shift_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stage[1] == $past(stage[0]));
endmodule

// File: rtl/tmpe_ctx_seq.sv
module tmpe_ctx_seq
  import tmpe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_we,
  input  logic [CTX_W:0]   cfg_addr,
  input  logic [WORD_W-1:0] cfg_data,
  output ctx_word_t        cur,
  output logic [CTX_W-1:0] slot
);
  ctx_word_t        mem [NCTX];
  logic [CTX_W-1:0] ii_m1;
  logic             wr_ok;

  assign wr_ok = cfg_we && !run;

  for (genvar g = 0; g < NCTX; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (wr_ok && !cfg_addr[CTX_W] && cfg_addr[CTX_W-1:0] == CTX_W'(g))
        mem[g] <= ctx_word_t'(cfg_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ii_m1 <= '0;
    else if (wr_ok && cfg_addr[CTX_W])
      ii_m1 <= cfg_data[CTX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run)     slot <= '0;
    else if (slot == ii_m1) slot <= '0;
    else                    slot <= slot + 1'b1;
  end

  assign cur = mem[slot];

  // R6
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= ii_m1);
  // R6
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(run) && slot != '0 |-> slot == $past(slot) + 1'b1);
  // R7
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> slot == '0);
  // R9
  run_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(ii_m1));
endmodule

// File: rtl/tmpe_alu.sv
module tmpe_alu
  import tmpe_pkg::*;
#(
  parameter int W = DW
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_PA:   y = a;
      OP_PB:   y = b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/tmpe_tile.sv
module tmpe_tile
  import tmpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cfg_we,
  input  logic [CTX_W:0]    cfg_addr,
  input  logic [WORD_W-1:0] cfg_data,
  input  logic [DW-1:0]     in_a,
  input  logic [DW-1:0]     in_b,
  output logic [DW-1:0]     res_data,
  output logic              res_en,
  output logic [CTX_W-1:0]  ctx_slot
);
  logic [DEPTH-1:0][DW-1:0] taps_a, taps_b;
  ctx_word_t                cur;
  logic [DW-1:0]            opa, opb, alu_y;

  tmpe_delay_line #(.W(DW), .N(DEPTH)) u_line_a (
    .clk(clk), .rst_n(rst_n), .din(in_a), .taps(taps_a));
  tmpe_delay_line #(.W(DW), .N(DEPTH)) u_line_b (
    .clk(clk), .rst_n(rst_n), .din(in_b), .taps(taps_b));

  tmpe_ctx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cur(cur), .slot(ctx_slot));

  assign opa = taps_a[cur.tap_a];
  assign opb = taps_b[cur.tap_b];

  tmpe_alu #(.W(DW)) u_alu (.op(cur.op), .a(opa), .b(opb), .y(alu_y));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_en   <= 1'b0;
      res_data <= '0;
    end else begin
      res_en <= run && cur.oe;
      if (run && cur.oe) res_data <= alu_y;
    end
  end

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !res_en);
  // R5
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_en |-> $stable(res_data));
endmodule

// File: tb/tmpe_tile_tb_top.sv
`timescale 1ns/1ps
module tmpe_tile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [11:0] cfg_data = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [31:0] res_data;
  logic        res_en;
  logic [3:0]  ctx_slot;

  always #2 clk = ~clk;

  tmpe_tile dut_i (.clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_a(in_a), .in_b(in_b),
    .res_data(res_data), .res_en(res_en), .ctx_slot(ctx_slot));

  int errors = 0;
  int checks = 0;

  // model state
  logic [31:0] ha [16];
  logic [31:0] hb [16];
  logic [11:0] mw [16];
  int          m_ii = 1;
  int          m_slot = 0;
  logic [31:0] m_data = '0;

  // scoreboard
  logic [36:0] exp_q [$];
  string       tag_q [$];
  string       tag = "R2";

  function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a;
      3'd6: return b;
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic r,
                      input logic we, input logic [4:0] ad, input logic [11:0] d);
    logic [11:0] w;
    logic        en;
    @(negedge clk);
    in_a = a; in_b = b; run = r; cfg_we = we; cfg_addr = ad; cfg_data = d;
    w  = mw[m_slot];
    en = r && w[11];
    if (en) m_data = ref_alu(w[2:0], ha[w[6:3]], hb[w[10:7]]);
    for (int k = 15; k > 0; k--) begin ha[k] = ha[k-1]; hb[k] = hb[k-1]; end
    ha[0] = a; hb[0] = b;
    if (!r) m_slot = 0;
    else m_slot = (m_slot == m_ii - 1) ? 0 : m_slot + 1;
    if (we && !r) begin
      if (ad[4]) m_ii = int'(d[3:0]) + 1;
      else mw[ad[3:0]] = d;
    end
    exp_q.push_back({en, m_data, 4'(m_slot)});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step($urandom, $urandom, 1'b0, 1'b0, 5'd0, 12'd0);
  endtask

  task automatic go(input int n);
    for (int i = 0; i < n; i++) step($urandom, $urandom, 1'b1, 1'b0, 5'd0, 12'd0);
  endtask

  task automatic wr(input logic [4:0] ad, input logic [11:0] d);
    step($urandom, $urandom, 1'b0, 1'b1, ad, d);
  endtask

  function automatic logic [11:0] word(input logic oe, input logic [3:0] tb, input logic [3:0] ta, input logic [2:0] op);
    return {oe, tb, ta, op};
  endfunction

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, expv);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [36:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " res_en"},   64'(res_en),   64'(e[36]));
      chk({t, " res_data"}, 64'(res_data), 64'(e[35:4]));
      chk({t, " ctx_slot"}, 64'(ctx_slot), 64'(e[3:0]));
    end
  end

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) begin ha[k] = '0; hb[k] = '0; mw[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 res_en", 64'(res_en), 64'd0);
    chk("R1 res_data", 64'(res_data), 64'd0);
    chk("R1 ctx_slot", 64'(ctx_slot), 64'd0);
    // R1: zero contexts, II=1 -> slot stays 0, output stays disabled
    tag = "R1"; go(4);
    // R2/R3: II=1, add of tap0 and tap0
    tag = "R2"; idle(1); wr(5'd0, word(1'b1, 4'd0, 4'd0, 3'd0)); go(20);
    // R2 deep taps: pass A from tap 15, then pass B from tap 9
    idle(1); wr(5'd0, word(1'b1, 4'd9, 4'd15, 3'd5)); go(20);
    idle(1); wr(5'd0, word(1'b1, 4'd9, 4'd15, 3'd6)); go(20);
    // R3 R4 R5 R6: II=4 mixed ops, slot 2 disabled, slot 3 enabled at wrap
    tag = "R6"; idle(1);
    wr(5'd0, word(1'b1, 4'd1, 4'd3, 3'd1));
    wr(5'd1, word(1'b1, 4'd0, 4'd15, 3'd4));
    wr(5'd2, word(1'b0, 4'd7, 4'd5, 3'd2));
    wr(5'd3, word(1'b1, 4'd9, 4'd2, 3'd3));
    wr(5'd16, 12'd3);
    go(40);
    // R9: writes while running are ignored
    tag = "R9";
    step($urandom, $urandom, 1'b1, 1'b1, 5'd3, word(1'b0, 4'd0, 4'd0, 3'd7));
    step($urandom, $urandom, 1'b1, 1'b1, 5'd16, 12'd0);
    go(20);
    // R7: run drop then restart from slot 0
    tag = "R7"; idle(3); go(9); idle(1); go(6);
    // R3 R6: II=16, all opcodes, slot 15 enabled at wrap
    tag = "R3"; idle(1);
    for (int i = 0; i < 16; i++)
      wr(5'(i), word(1'b1, 4'(15 - i), 4'(i), 3'(i)));
    wr(5'd16, 12'd15);
    go(70);
    // R8: II back to 2 with a sparse enable pattern
    tag = "R8"; idle(1);
    wr(5'd1, word(1'b0, 4'd0, 4'd0, 3'd0));
    wr(5'd16, 12'd1);
    go(20);
    idle(2);
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule